// File: doc/BRIEF.md
# I2C Transaction Queue Register Interface

This block sits between a host processor and an I2C bit engine on one bus channel. The host builds a queue of up to eight transactions through a byte-wide register port. Each transaction has a slave address, whose least significant bit gives the direction, a length, and a run of payload bytes. The block keeps these in internal tables and in a 64-byte payload buffer. A separate auto-increment pointer walks each table, so the host can fill a whole queue by writing the same register address over and over.

The bit engine reads the tables through a combinational lookup port. The port gives the slave address, the direction, the length and the payload base of any selected transaction, and any payload byte by index. The engine writes received bytes back into the buffer through its own write port, and the host reads them out through the data window. Control-register writes become single-cycle start and stop strobes. A start can instead be armed to fire on an edge of an external trigger input.

The host request channel is valid/ready. `host_ready` is low while reset is asserted and high after it. An access takes effect on each rising edge where `host_valid` and `host_ready` are both high, so at most one access completes per cycle. Every accepted read produces exactly one response, with `rsp_valid` high for one cycle on the following cycle. The response channel has no back-pressure: the host must take the response in that cycle.

Top module: `i2cq_regif`

## Requirements
- R1: A write of a control byte with bit 1 set clears the slave-table pointer, the length pointer and the data pointer to zero. It re-arms the count capture and clears the overflow flag.
- R2: Each host write to register address 1 stores the byte at the slave-table pointer and then advances that pointer by one. On the engine port, `eng_is_read` equals bit 0 of the stored address (1 = read, 0 = write).
- R3: The first write to register address 2 after a pointer clear sets the transaction count, saturating at 8. Each later write to that address stores the length of the next transaction in order.
- R4: The payload base of transaction k is the sum of the lengths of transactions 0 to k-1. A write of k to address 3 moves the data pointer to that base. A write of an offset to address 4 moves it to the base of the selected transaction plus the offset.
- R5: Each host access to address 5 writes or reads the byte at the data pointer, and the pointer then advances by one. The read byte appears on `rsp_data` with `rsp_valid` one cycle after acceptance.
- R6: A byte the engine writes through `eng_wr_en` is stored in the buffer. It can then be read back through the data window and the engine read port. If the engine and the host write the same index in the same cycle, the engine byte is kept.
- R7: A control write of 0x40 (bit 6 set, bit 3 clear) raises `start_pulse` for exactly the one cycle after acceptance.
- R8: A control write with bits 6 and 3 set arms a triggered start, shown on `trig_armed`. Bit 4 = 1 selects a rising edge of `trig_in` and bit 4 = 0 a falling edge, both seen after a two-flop synchroniser. The chosen edge gives one `start_pulse` and disarms. The opposite edge has no effect.
- R9: A control write with bit 5 set (0x20) raises `stop_pulse` for exactly one cycle.
- R10: The overflow flag is sticky and is set by any of these: a slave-table or length write while its pointer has reached 8, a data access while the data pointer has reached 64, a select or offset target of 64 or more, or a count above 8. An out-of-range table write lands at index 0. A data pointer or target past the limit wraps modulo 64.
- R11: `host_ready` is 0 in reset and 1 afterwards. A read of any address other than 5 returns 0x00 and still produces one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register: 0 control, 1 slave table, 2 config, 3 select, 4 offset, 5 data |
| host_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid (one cycle) |
| rsp_data | output | 8 | Read response byte |
| trig_in | input | 1 | Asynchronous start trigger |
| start_pulse | output | 1 | Start strobe to the bit engine |
| stop_pulse | output | 1 | Stop strobe to the bit engine |
| trig_armed | output | 1 | Triggered start is pending |
| txn_count | output | 4 | Number of queued transactions |
| ovf_flag | output | 1 | Sticky pointer overflow |
| eng_txn_sel | input | 3 | Transaction looked up by the engine |
| eng_slave_addr | output | 8 | Stored slave address of that transaction |
| eng_is_read | output | 1 | Direction bit of that address |
| eng_len | output | 8 | Length of that transaction |
| eng_base | output | 6 | Payload base index of that transaction |
| eng_byte_idx | input | 6 | Payload index read by the engine |
| eng_byte | output | 8 | Payload byte at that index |
| eng_wr_en | input | 1 | Engine payload write enable |
| eng_wr_idx | input | 6 | Engine payload write index |
| eng_wr_data | input | 8 | Engine payload write byte |

## Verification
The queue is loaded with three transactions of unequal lengths, and the data window is then reached in several ways. Selecting by transaction checks the prefix-sum bases. Selecting with an offset checks the added displacement. A read that runs past a transaction's end shows that the pointer is one flat cursor, not one per transaction. Engine write-backs that overwrite host bytes separate buffer readback from a shadow copy. Trigger arming is tried with both polarities, with the wrong edge first and then the right one. Each table is also driven exactly to its limit and one step beyond, which tells a legal full table apart from a wrap that sets overflow.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_SLA  = 3'd1,
    REG_CFG  = 3'd2,
    REG_SEL  = 3'd3,
    REG_OFS  = 3'd4,
    REG_DATA = 3'd5
  } reg_e;

  localparam int CB_PRST  = 1;
  localparam int CB_TRIG  = 3;
  localparam int CB_POL   = 4;
  localparam int CB_STOP  = 5;
  localparam int CB_START = 6;
endpackage

// File: rtl/i2cq_ctrl.sv
module i2cq_ctrl
  import i2cq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [DW-1:0] ctrl_wdata,
  input  logic          trig_in,
  output logic          ptr_rst,
  output logic          start_pulse,
  output logic          stop_pulse,
  output logic          armed
);
  logic sync1, sync2, sync3;
  logic pol_rise;
  logic imm_start, arm_req, hit;

  assign ptr_rst   = ctrl_we & ctrl_wdata[CB_PRST];
  assign imm_start = ctrl_we & ctrl_wdata[CB_START] & ~ctrl_wdata[CB_TRIG];
  assign arm_req   = ctrl_we & ctrl_wdata[CB_START] & ctrl_wdata[CB_TRIG];
  assign hit       = armed & (pol_rise ? (sync2 & ~sync3) : (~sync2 & sync3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= trig_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      armed       <= 1'b0;
      pol_rise    <= 1'b0;
    end else begin
      start_pulse <= imm_start | hit;
      stop_pulse  <= ctrl_we & ctrl_wdata[CB_STOP];
      if (arm_req) begin
        armed    <= 1'b1;
        pol_rise <= ctrl_wdata[CB_POL];
      end else if (hit | imm_start | (ctrl_we & ctrl_wdata[CB_STOP])) begin
        armed <= 1'b0;
      end
    end
  end

  AST_IMM_START: assert property (@(posedge clk) disable iff (!rst_n)
    imm_start |=> start_pulse); // R7
  AST_STOP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[CB_STOP]) |=> stop_pulse); // R9
  AST_TRIG_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ctrl_we) |=> (!armed && start_pulse)); // R8
endmodule

// File: rtl/i2cq_tables.sv
module i2cq_tables #(
  parameter int NTXN = 8,
  parameter int DW   = 8,
  parameter int TW   = 3,
  parameter int CW   = 4,
  parameter int BW   = 6,
  parameter int SW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_rst,
  input  logic          sla_we,
  input  logic          cfg_we,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] host_idx,
  input  logic [TW-1:0] eng_idx,
  output logic [CW-1:0] count,
  output logic [DW-1:0] eng_slave,
  output logic [DW-1:0] eng_len,
  output logic [BW-1:0] eng_base,
  output logic [SW-1:0] host_base,
  output logic          ovf_evt
);
  localparam logic [TW:0]   LIM   = (TW+1)'(NTXN);
  localparam logic [DW-1:0] LIMD  = DW'(NTXN);
  localparam logic [CW-1:0] LIMC  = CW'(NTXN);

  logic [DW-1:0] sla_mem [NTXN];
  logic [DW-1:0] len_mem [NTXN];
  logic [TW:0]   sla_ptr, len_ptr;
  logic [TW-1:0] sla_wi, len_wi;
  logic          cfg_first;
  logic [SW-1:0] pre [NTXN+1];

  assign sla_wi = (sla_ptr == LIM) ? '0 : sla_ptr[TW-1:0];
  assign len_wi = (len_ptr == LIM) ? '0 : len_ptr[TW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sla_ptr   <= '0;
      len_ptr   <= '0;
      cfg_first <= 1'b1;
      count     <= '0;
      for (int i = 0; i < NTXN; i++) begin
        sla_mem[i] <= '0;
        len_mem[i] <= '0;
      end
    end else begin
      if (ptr_rst) begin
        sla_ptr   <= '0;
        len_ptr   <= '0;
        cfg_first <= 1'b1;
      end
      if (sla_we) begin
        sla_mem[sla_wi] <= wdata;
        sla_ptr         <= {1'b0, sla_wi} + 1'b1;
      end
      if (cfg_we) begin
        if (cfg_first) begin
          count     <= (wdata > LIMD) ? LIMC : wdata[CW-1:0];
          cfg_first <= 1'b0;
        end else begin
          len_mem[len_wi] <= wdata;
          len_ptr         <= {1'b0, len_wi} + 1'b1;
        end
      end
    end
  end

  assign pre[0] = '0;
  for (genvar g = 0; g < NTXN; g++) begin : g_prefix
    assign pre[g+1] = pre[g] + SW'(len_mem[g]);
  end

  assign host_base = pre[host_idx];
  assign eng_base  = pre[eng_idx][BW-1:0];
  assign eng_slave = sla_mem[eng_idx];
  assign eng_len   = len_mem[eng_idx];

  assign ovf_evt = (sla_we && sla_ptr == LIM)
                 || (cfg_we && !cfg_first && len_ptr == LIM)
                 || (cfg_we && cfg_first && wdata > LIMD);

  AST_PRST_TABLES: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |=> (sla_ptr == '0 && len_ptr == '0 && cfg_first)); // R1
  AST_SLA_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sla_we && sla_ptr != LIM) |=> (sla_ptr == $past(sla_ptr) + 1'b1)); // R2
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIMC); // R3
endmodule

// File: rtl/i2cq_payload.sv
module i2cq_payload #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int TW    = 3,
  parameter int BW    = 6,
  parameter int SW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_rst,
  input  logic          sel_we,
  input  logic          ofs_we,
  input  logic          data_we,
  input  logic          data_re,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] host_base,
  output logic [TW-1:0] sel_q,
  output logic [DW-1:0] rd_byte,
  output logic          ovf_evt,
  input  logic [BW-1:0] eng_rd_idx,
  output logic [DW-1:0] eng_rd_byte,
  input  logic          eng_wr_en,
  input  logic [BW-1:0] eng_wr_idx,
  input  logic [DW-1:0] eng_wr_data
);
  localparam logic [BW:0]   LIM  = (BW+1)'(DEPTH);
  localparam logic [SW-1:0] LIMS = SW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [BW:0]   ptr;
  logic [BW-1:0] ptr_eff;
  logic [SW-1:0] target;
  logic          tgt_ovf, data_acc;

  assign ptr_eff  = (ptr == LIM) ? '0 : ptr[BW-1:0];
  assign data_acc = data_we | data_re;
  assign target   = ofs_we ? (host_base + SW'(wdata)) : host_base;
  assign tgt_ovf  = target >= LIMS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      sel_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (ptr_rst) ptr <= '0;
      if (sel_we) begin
        sel_q <= wdata[TW-1:0];
        ptr   <= {1'b0, target[BW-1:0]};
      end
      if (ofs_we) ptr <= {1'b0, target[BW-1:0]};
      if (data_acc) ptr <= {1'b0, ptr_eff} + 1'b1;
      if (data_we) mem[ptr_eff] <= wdata;
      if (eng_wr_en) mem[eng_wr_idx] <= eng_wr_data;
    end
  end

  assign rd_byte     = mem[ptr_eff];
  assign eng_rd_byte = mem[eng_rd_idx];
  assign ovf_evt     = (data_acc && ptr == LIM) || ((sel_we || ofs_we) && tgt_ovf);

  AST_DATA_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && ptr != LIM) |=> (ptr == $past(ptr) + 1'b1)); // R5
  AST_PRST_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rst && !sel_we && !ofs_we && !data_acc) |=> (ptr == '0)); // R1
  AST_ENG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr_en |=> (mem[$past(eng_wr_idx)] == $past(eng_wr_data))); // R6
endmodule

// File: rtl/i2cq_regif.sv
module i2cq_regif
  import i2cq_pkg::*;
#(
  parameter int NTXN      = 8,
  parameter int BUF_DEPTH = 64,
  parameter int DW        = 8,
  localparam int TW = $clog2(NTXN),
  localparam int BW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(NTXN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic          host_write,
  input  logic [2:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic          trig_in,
  output logic          start_pulse,
  output logic          stop_pulse,
  output logic          trig_armed,
  output logic [CW-1:0] txn_count,
  output logic          ovf_flag,
  input  logic [TW-1:0] eng_txn_sel,
  output logic [DW-1:0] eng_slave_addr,
  output logic          eng_is_read,
  output logic [DW-1:0] eng_len,
  output logic [BW-1:0] eng_base,
  input  logic [BW-1:0] eng_byte_idx,
  output logic [DW-1:0] eng_byte,
  input  logic          eng_wr_en,
  input  logic [BW-1:0] eng_wr_idx,
  input  logic [DW-1:0] eng_wr_data
);
  localparam int SW = DW + TW + 1;

  logic          ready_q, acc, wr_acc, rd_acc;
  logic          ctrl_we, sla_we, cfg_we, sel_we, ofs_we, data_we, data_re;
  logic          ptr_rst, tab_ovf, pay_ovf;
  logic [TW-1:0] sel_q, sel_idx;
  logic [SW-1:0] host_base;
  logic [DW-1:0] rd_byte;

  assign host_ready = ready_q;
  assign acc     = host_valid & ready_q;
  assign wr_acc  = acc & host_write;
  assign rd_acc  = acc & ~host_write;
  assign ctrl_we = wr_acc && host_addr == REG_CTRL;
  assign sla_we  = wr_acc && host_addr == REG_SLA;
  assign cfg_we  = wr_acc && host_addr == REG_CFG;
  assign sel_we  = wr_acc && host_addr == REG_SEL;
  assign ofs_we  = wr_acc && host_addr == REG_OFS;
  assign data_we = wr_acc && host_addr == REG_DATA;
  assign data_re = rd_acc && host_addr == REG_DATA;
  assign sel_idx = sel_we ? host_wdata[TW-1:0] : sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      ovf_flag  <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_data <= data_re ? rd_byte : '0;
      if (ptr_rst) ovf_flag <= 1'b0;
      else if (tab_ovf | pay_ovf) ovf_flag <= 1'b1;
    end
  end

  i2cq_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(host_wdata),
    .trig_in(trig_in), .ptr_rst(ptr_rst), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .armed(trig_armed)
  );

  i2cq_tables #(.NTXN(NTXN), .DW(DW), .TW(TW), .CW(CW), .BW(BW), .SW(SW)) u_tables (
    .clk(clk), .rst_n(rst_n), .ptr_rst(ptr_rst), .sla_we(sla_we), .cfg_we(cfg_we),
    .wdata(host_wdata), .host_idx(sel_idx), .eng_idx(eng_txn_sel), .count(txn_count),
    .eng_slave(eng_slave_addr), .eng_len(eng_len), .eng_base(eng_base),
    .host_base(host_base), .ovf_evt(tab_ovf)
  );

  i2cq_payload #(.DEPTH(BUF_DEPTH), .DW(DW), .TW(TW), .BW(BW), .SW(SW)) u_payload (
    .clk(clk), .rst_n(rst_n), .ptr_rst(ptr_rst), .sel_we(sel_we), .ofs_we(ofs_we),
    .data_we(data_we), .data_re(data_re), .wdata(host_wdata), .host_base(host_base),
    .sel_q(sel_q), .rd_byte(rd_byte), .ovf_evt(pay_ovf), .eng_rd_idx(eng_byte_idx),
    .eng_rd_byte(eng_byte), .eng_wr_en(eng_wr_en), .eng_wr_idx(eng_wr_idx),
    .eng_wr_data(eng_wr_data)
  );

  assign eng_is_read = eng_slave_addr[0];

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ptr_rst) |=> ovf_flag); // R10
  AST_RSP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid); // R11
  AST_NO_RSP_WO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid); // R11
endmodule

// File: tb/i2cq_regif_bench.sv
module i2cq_regif_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 0, host_write = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic host_ready, rsp_valid, start_pulse, stop_pulse, trig_armed, ovf_flag, eng_is_read;
  logic [7:0] rsp_data, eng_slave_addr, eng_len, eng_byte;
  logic [3:0] txn_count;
  logic [5:0] eng_base;
  logic trig_in = 0;
  logic [2:0] eng_txn_sel = 0;
  logic [5:0] eng_byte_idx = 0, eng_wr_idx = 0;
  logic eng_wr_en = 0;
  logic [7:0] eng_wr_data = 0;

  int n_chk = 0, n_fail = 0, start_cnt = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  i2cq_regif u_i2cq_regif (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic acc(input bit w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_valid = 1; host_write = w; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    acc(1'b1, a, d);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    acc(1'b0, a, 8'h00);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R11 unexpected response", rsp_data, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        eq(t, rsp_data, e);
      end
    end
    if (start_pulse) start_cnt++;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int sc;
    repeat (3) @(negedge clk);
    eq("R11 ready low in reset", host_ready, 0);
    rst_n = 1;
    @(negedge clk);
    eq("R11 ready after reset", host_ready, 1);
    eq("R1 ovf reset", ovf_flag, 0);
    eq("R3 count reset", txn_count, 0);
    eq("R7 no start in reset", start_pulse, 0);

    // load queue: 3 transactions, lengths 4,2,5
    wr(0, 8'h02);
    wr(1, 8'hA0); wr(1, 8'h51); wr(1, 8'h3C);
    wr(2, 8'd3); wr(2, 8'd4); wr(2, 8'd2); wr(2, 8'd5);
    for (int i = 0; i < 11; i++) wr(5, 8'h10 + 8'(i));
    eq("R3 count", txn_count, 3);
    eng_txn_sel = 1; #1;
    eq("R2 slave[1]", eng_slave_addr, 8'h51);
    eq("R2 dir read", eng_is_read, 1);
    eq("R3 len[1]", eng_len, 2);
    eq("R4 base[1]", eng_base, 4);
    eng_txn_sel = 2; #1;
    eq("R4 base[2]", eng_base, 6);
    eq("R3 len[2]", eng_len, 5);
    eng_txn_sel = 0; #1;
    eq("R2 dir write", eng_is_read, 0);
    eng_byte_idx = 10; #1;
    eq("R5 payload idx10", eng_byte, 8'h1A);

    // data window by transaction select
    wr(3, 8'd2);
    for (int i = 0; i < 5; i++) rd(5, 8'h16 + 8'(i), "R4 R5 select-2 read");
    wr(3, 8'd1); wr(4, 8'd1);
    rd(5, 8'h15, "R4 offset read");
    rd(5, 8'h16, "R5 read runs into next txn");

    // engine write-back
    @(negedge clk);
    eng_wr_en = 1; eng_wr_idx = 4; eng_wr_data = 8'hEE;
    @(negedge clk);
    eng_wr_idx = 5; eng_wr_data = 8'hDD;
    @(negedge clk);
    eng_wr_en = 0;
    wr(3, 8'd1);
    rd(5, 8'hEE, "R6 engine byte 0");
    rd(5, 8'hDD, "R6 engine byte 1");
    // collision: engine wins
    @(negedge clk);
    host_valid = 1; host_write = 1; host_addr = 5; host_wdata = 8'h44;
    eng_wr_en = 1; eng_wr_idx = 6; eng_wr_data = 8'h99;
    @(negedge clk);
    host_valid = 0; eng_wr_en = 0;
    eng_byte_idx = 6; #1;
    eq("R6 collision engine wins", eng_byte, 8'h99);
    rd(2, 8'h00, "R11 non-data read zero");

    // immediate start and stop
    sc = start_cnt;
    wr(0, 8'h40);
    eq("R7 start pulse", start_pulse, 1);
    @(negedge clk);
    eq("R7 start self-clear", start_pulse, 0);
    wr(0, 8'h20);
    eq("R9 stop pulse", stop_pulse, 1);
    @(negedge clk);
    eq("R9 stop self-clear", stop_pulse, 0);
    eq("R7 one start counted", start_cnt - sc, 1);

    // triggered start, rising
    sc = start_cnt;
    wr(0, 8'h58);
    eq("R8 armed", trig_armed, 1);
    trig_in = 1;
    repeat (6) @(negedge clk);
    eq("R8 rising fires once", start_cnt - sc, 1);
    eq("R8 disarm", trig_armed, 0);
    // falling armed, rising ignored
    trig_in = 0;
    repeat (6) @(negedge clk);
    sc = start_cnt;
    wr(0, 8'h48);
    trig_in = 1;
    repeat (6) @(negedge clk);
    eq("R8 wrong edge ignored", start_cnt - sc, 0);
    eq("R8 still armed", trig_armed, 1);
    trig_in = 0;
    repeat (6) @(negedge clk);
    eq("R8 falling fires", start_cnt - sc, 1);

    // slave table overflow
    wr(0, 8'h02);
    for (int i = 0; i < 8; i++) wr(1, 8'h60 + 8'(i));
    eq("R10 full table no ovf", ovf_flag, 0);
    eng_txn_sel = 7; #1;
    eq("R2 slave[7]", eng_slave_addr, 8'h67);
    wr(1, 8'h99);
    eq("R10 sla overflow", ovf_flag, 1);
    eng_txn_sel = 0; #1;
    eq("R10 sla wrap to 0", eng_slave_addr, 8'h99);
    wr(3, 8'd0);
    eq("R10 sticky", ovf_flag, 1);
    wr(0, 8'h02);
    eq("R1 ovf cleared", ovf_flag, 0);

    // data pointer overflow
    wr(3, 8'd0); wr(4, 8'd63);
    wr(5, 8'h77);
    eq("R10 last byte no ovf", ovf_flag, 0);
    wr(5, 8'h88);
    eq("R10 data overflow", ovf_flag, 1);
    eng_byte_idx = 0; #1;
    eq("R10 data wrap idx0", eng_byte, 8'h88);
    wr(0, 8'h02);
    wr(3, 8'd0); wr(4, 8'd63);
    rd(5, 8'h77, "R5 read idx63");
    rd(5, 8'h88, "R10 read wraps");
    wr(0, 8'h02);
    wr(3, 8'd2); wr(4, 8'd60);
    eq("R10 offset target overflow", ovf_flag, 1);
    rd(5, 8'h12, "R10 offset wraps to idx2");

    // count saturation
    wr(0, 8'h02);
    wr(2, 8'd12);
    eq("R3 count saturates", txn_count, 8);
    eq("R10 count overflow", ovf_flag, 1);

    repeat (3) @(negedge clk);
    eq("R11 all responses seen", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule